// File: doc/BRIEF.md
# Register-Program Load/Store Executor

This block walks a program of 32-bit command words held in host memory and carries out two register-transfer commands. A load command copies the data words that follow its header into a run of consecutive internal registers. A store command takes the next word as a 32-bit host byte address and writes the contents of one internal register there. Every other opcode is skipped as a one-word no-operation and flagged.

The executor fetches words through a request/valid port, one word per accepted cycle, and the program pointer advances by four bytes per word. It drives a write port into host memory and a one-access-per-clock port into a small register file that it does not hold itself. A register index past the end of that file is never accessed. Instead a sticky error bit is set, which can raise an interrupt, and execution goes on. A load still consumes all of its data words, so the next command is found where the program expects it.

Top module: `regprog_exec`

## Requirements
- R1: After reset the executor requests the program word at byte address PROG_BASE, holds the memory write port idle, and shows the error bit clear.
- R2: Header word fields: bits 31:28 are the opcode (4'b1001 = load, 4'b1010 = store), bits 15:8 are the word count, and bits 6:0 are the register index. Bits 27:16 and bit 7 have no effect on execution.
- R3: A load with count N writes the N data words that follow the header to register indices idx, idx+1, …, idx+N-1, in that order. The index does not wrap at 7 bits.
- R4: A load or store header with a count of zero occupies one word and does nothing. The very next word is decoded as a header.
- R5: A store with a nonzero count is two words long. The second word is the host byte address, and the value of the indexed register at that time is written there once. A register access and a memory write never happen in the same cycle.
- R6: An access to an index at or above REG_COUNT is not performed and sets the error bit. A load always consumes all N data words, and a store with a bad index issues no memory write.
- R7: The error bit stays set until err_clr is pulsed. If a set and a clear fall in the same cycle, the set wins. irq equals the error bit ANDed with irq_en.
- R8: A header with any other opcode is consumed as a single word, and unsup pulses for exactly the cycle in which that word is accepted.
- R9: While fetch_valid is low, the fetch request and its address hold steady. While mw_ready is low, the pending memory write holds its address and data.
- R10: Each accepted word moves the program pointer on by 4 bytes. The header after a command is fetched from the word that directly follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | output | 1 | Program word requested |
| fetch_addr | output | 32 | Byte address of requested word |
| fetch_valid | input | 1 | fetch_data holds the requested word this cycle |
| fetch_data | input | 32 | Program word |
| mw_valid | output | 1 | Host memory write pending |
| mw_addr | output | 32 | Host byte address of the write |
| mw_data | output | 32 | Write data |
| mw_ready | input | 1 | Host accepts the write this cycle |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 9 | Register index for the read or write |
| rf_wdata | output | 32 | Register write data |
| rf_rdata | input | 32 | Combinational read data at rf_idx |
| err_clr | input | 1 | One-cycle clear of the error bit |
| irq_en | input | 1 | Interrupt enable |
| rd_err | output | 1 | Sticky bad-index error |
| irq | output | 1 | Interrupt request |
| unsup | output | 1 | Pulse: unsupported opcode skipped |

## Verification
The bench builds the executor with REG_COUNT = 12 and PROG_BASE = 0. With only twelve registers, every load start index from 0 to 13 combined with every count from 1 to 4 can be swept in full. Those runs cover loads that fit exactly, loads that straddle the end of the file, and loads that lie entirely past it, together with stores of just-loaded, untouched and out-of-range registers. Every other run throttles fetch_valid and mw_ready, so each program also runs under stalls. Zero-count headers and unknown opcodes sit between commands, which shows that each one occupies exactly one word.

// File: rtl/regprog_pkg.sv
// Shared constants and types for the register-program executor.
// Assumes 32-bit program words and a register file of at most 128 entries.
package regprog_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 7;
    localparam int LEN_W  = 8;
    // Running index width: a 7-bit start plus up to 255 steps never wraps.
    localparam int IDXC_W = IDX_W + 2;

    localparam logic [3:0] OP_LOAD  = 4'b1001;
    localparam logic [3:0] OP_STORE = 4'b1010;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_LOAD,
        ST_SADDR,
        ST_SWR
    } exec_state_t;

    typedef struct packed {
        logic             is_load;
        logic             is_store;
        logic             is_nop;
        logic             is_unsup;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] idx;
    } hdr_t;
endpackage

// File: rtl/regprog_decode.sv
// Header decoder: classifies a program word as load, store, zero-count
// no-op or unsupported, and extracts count and register index.
// Assumes reserved bits carry no meaning; they are not examined.
module regprog_decode
    import regprog_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);
    logic [3:0] op;
    logic       zero_len;
    logic       known;

    // Split fields and classify the opcode.
    always_comb begin
        op           = word[31:28];
        zero_len     = (word[15:8] == '0);
        known        = (op == OP_LOAD) || (op == OP_STORE);
        hdr.len      = word[15:8];
        hdr.idx      = word[6:0];
        hdr.is_load  = (op == OP_LOAD)  && !zero_len;
        hdr.is_store = (op == OP_STORE) && !zero_len;
        hdr.is_nop   = known && zero_len;
        hdr.is_unsup = !known;
    end
endmodule

// File: rtl/regprog_errstat.sv
// Sticky bad-index error bit with gated interrupt.
// Assumes set and clear are single-cycle strobes; set has priority.
module regprog_errstat (
    input  logic clk,
    input  logic rst_n,
    input  logic set_err,
    input  logic clr_err,
    input  logic irq_en,
    output logic err,
    output logic irq
);
    // Hold the error until cleared; a new error in the clear cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (set_err) err <= 1'b1;
        else if (clr_err) err <= 1'b0;
    end

    // Interrupt is the error gated by its enable.
    always_comb irq = err && irq_en;
endmodule

// File: rtl/regprog_seq.sv
// Command sequencer: fetches words, runs load bursts and store pairs,
// skips bad register indices while still consuming their words.
// Assumes the register file read is combinational on rf_idx.
module regprog_seq
    import regprog_pkg::*;
#(
    parameter int               REG_COUNT = 24,
    parameter logic [WORD_W-1:0] PROG_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req,
    output logic [WORD_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_data,
    input  hdr_t              hdr,
    output logic              mw_valid,
    output logic [WORD_W-1:0] mw_addr,
    output logic [WORD_W-1:0] mw_data,
    input  logic              mw_ready,
    output logic              rf_we,
    output logic [IDXC_W-1:0] rf_idx,
    output logic [WORD_W-1:0] rf_wdata,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              bad_access,
    output logic              unsup
);
    localparam logic [IDXC_W-1:0] LIMIT = IDXC_W'(REG_COUNT);

    exec_state_t       state;
    logic [WORD_W-1:0] pc;
    logic [IDXC_W-1:0] cur_idx;
    logic [LEN_W-1:0]  remain;
    logic [WORD_W-1:0] st_addr;
    logic [WORD_W-1:0] st_data;
    logic              take;
    logic              idx_ok;
    logic              accessing;

    // Port drive and per-cycle strobes.
    always_comb begin
        fetch_req  = (state == ST_HDR) || (state == ST_LOAD) || (state == ST_SADDR);
        fetch_addr = pc;
        take       = fetch_req && fetch_valid;
        idx_ok     = cur_idx < LIMIT;
        accessing  = take && ((state == ST_LOAD) || (state == ST_SADDR));
        rf_idx     = cur_idx;
        rf_wdata   = fetch_data;
        rf_we      = accessing && (state == ST_LOAD) && idx_ok;
        bad_access = accessing && !idx_ok;
        unsup      = take && (state == ST_HDR) && hdr.is_unsup;
        mw_valid   = (state == ST_SWR);
        mw_addr    = st_addr;
        mw_data    = st_data;
    end

    // Command state machine and program pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HDR;
            pc      <= PROG_BASE;
            cur_idx <= '0;
            remain  <= '0;
            st_addr <= '0;
            st_data <= '0;
        end else begin
            if (take) pc <= pc + WORD_W'(4);
            case (state)
                ST_HDR: begin
                    if (take) begin
                        cur_idx <= IDXC_W'(hdr.idx);
                        remain  <= hdr.len;
                        if (hdr.is_load)       state <= ST_LOAD;
                        else if (hdr.is_store) state <= ST_SADDR;
                    end
                end
                ST_LOAD: begin
                    if (take) begin
                        cur_idx <= cur_idx + 1'b1;
                        remain  <= remain - 1'b1;
                        if (remain == LEN_W'(1)) state <= ST_HDR;
                    end
                end
                ST_SADDR: begin
                    if (take) begin
                        st_addr <= fetch_data;
                        st_data <= rf_rdata;
                        state   <= idx_ok ? ST_SWR : ST_HDR;
                    end
                end
                default: begin
                    if (mw_ready) state <= ST_HDR;
                end
            endcase
        end
    end
endmodule

// File: rtl/regprog_exec.sv
// Top of the register-program executor: decoder, sequencer, error status.
// Assumes REG_COUNT <= 128 and a word-aligned PROG_BASE.
module regprog_exec
    import regprog_pkg::*;
#(
    parameter int               REG_COUNT = 24,
    parameter logic [31:0]      PROG_BASE = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        fetch_req,
    output logic [31:0] fetch_addr,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_data,
    output logic        mw_valid,
    output logic [31:0] mw_addr,
    output logic [31:0] mw_data,
    input  logic        mw_ready,
    output logic        rf_we,
    output logic [8:0]  rf_idx,
    output logic [31:0] rf_wdata,
    input  logic [31:0] rf_rdata,
    input  logic        err_clr,
    input  logic        irq_en,
    output logic        rd_err,
    output logic        irq,
    output logic        unsup
);
    hdr_t hdr;
    logic bad_access;

    regprog_decode u_dec (
        .word (fetch_data),
        .hdr  (hdr)
    );

    regprog_seq #(
        .REG_COUNT (REG_COUNT),
        .PROG_BASE (PROG_BASE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .hdr         (hdr),
        .mw_valid    (mw_valid),
        .mw_addr     (mw_addr),
        .mw_data     (mw_data),
        .mw_ready    (mw_ready),
        .rf_we       (rf_we),
        .rf_idx      (rf_idx),
        .rf_wdata    (rf_wdata),
        .rf_rdata    (rf_rdata),
        .bad_access  (bad_access),
        .unsup       (unsup)
    );

    regprog_errstat u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_err (bad_access),
        .clr_err (err_clr),
        .irq_en  (irq_en),
        .err     (rd_err),
        .irq     (irq)
    );
endmodule

// File: rtl/regprog_exec_chk.sv
// Property checker for regprog_exec, attached by bind below.
module regprog_exec_chk #(
    parameter int REG_COUNT = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_req,
    input logic [31:0] fetch_addr,
    input logic        fetch_valid,
    input logic        mw_valid,
    input logic [31:0] mw_addr,
    input logic [31:0] mw_data,
    input logic        mw_ready,
    input logic        rf_we,
    input logic [8:0]  rf_idx,
    input logic        err_clr,
    input logic        irq_en,
    input logic        rd_err,
    input logic        irq
);
    AST_WRITE_IDX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (int'(rf_idx) < REG_COUNT)); // R6
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr))); // R9
    AST_MW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data))); // R9
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_valid) |=> (!fetch_req || fetch_addr == $past(fetch_addr) + 32'd4)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err && !err_clr) |=> rd_err); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && rd_err)); // R7
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && mw_valid)); // R5
endmodule

bind regprog_exec regprog_exec_chk #(.REG_COUNT(REG_COUNT)) u_chk (.*);

// File: tb/regprog_exec_tb_top.sv
module regprog_exec_tb_top;
    localparam int NREG = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_req, fetch_valid;
    logic [31:0] fetch_addr, fetch_data;
    logic        mw_valid, mw_ready;
    logic [31:0] mw_addr, mw_data;
    logic        rf_we;
    logic [8:0]  rf_idx;
    logic [31:0] rf_wdata, rf_rdata;
    logic        err_clr, irq_en, rd_err, irq, unsup;

    always #5 clk = ~clk;

    regprog_exec #(.REG_COUNT(NREG), .PROG_BASE(32'h0)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .err_clr(err_clr), .irq_en(irq_en), .rd_err(rd_err), .irq(irq), .unsup(unsup)
    );

    logic [31:0] prog [0:255];
    logic [31:0] regs [0:NREG-1];
    logic [31:0] wr_a [0:15];
    logic [31:0] wr_d [0:15];
    int nw, nunsup, nbad, cyc, stall_mode;
    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] exp_regs [0:NREG-1];
    logic [31:0] exp_wa [0:15];
    logic [31:0] exp_wd [0:15];
    int exp_nw, exp_unsup, ptr;
    bit exp_err;

    function automatic logic [31:0] init_val(int i);
        return 32'hA500_0000 + i;
    endfunction

    // Host memory, register file and throttling models.
    always_comb begin
        fetch_data  = prog[fetch_addr[9:2]];
        fetch_valid = fetch_req && (stall_mode == 0 || (cyc % 3) != 1);
        mw_ready    = (stall_mode == 0) || ((cyc % 2) == 0);
        rf_rdata    = (int'(rf_idx) < NREG) ? regs[rf_idx[3:0]] : 32'hDEAD_BEEF;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= init_val(i);
            nw <= 0; nunsup <= 0; nbad <= 0;
        end else begin
            if (rf_we) begin
                if (int'(rf_idx) < NREG) regs[rf_idx[3:0]] <= rf_wdata;
                else nbad <= nbad + 1;
            end
            if (mw_valid && mw_ready && nw < 16) begin
                wr_a[nw] <= mw_addr; wr_d[nw] <= mw_data; nw <= nw + 1;
            end
            if (unsup) nunsup <= nunsup + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(logic [31:0] w);
        prog[ptr] = w; ptr++;
    endtask

    // Load header with reserved bits set (R2) and its data words (R3).
    task automatic add_load(int s, int n);
        logic [31:0] d;
        put({4'b1001, 12'hF0F, 8'(n), 1'b1, 7'(s)});
        for (int k = 0; k < n; k++) begin
            d = 32'h3C00_0000 ^ (32'(ptr) << 12) ^ 32'(k);
            put(d);
            if (s + k < NREG) exp_regs[s + k] = d;
            else exp_err = 1;
        end
    endtask

    task automatic add_store(int s, logic [31:0] a);
        put({4'b1010, 12'h5A5, 8'd1, 1'b1, 7'(s)});
        put(a);
        if (s < NREG) begin
            exp_wa[exp_nw] = a; exp_wd[exp_nw] = exp_regs[s]; exp_nw++;
        end else exp_err = 1;
    endtask

    task automatic begin_run();
        @(negedge clk);
        rst_n = 0; err_clr = 0;
        for (int i = 0; i < 256; i++) prog[i] = 32'h0;
        for (int i = 0; i < NREG; i++) exp_regs[i] = init_val(i);
        exp_nw = 0; exp_unsup = 0; exp_err = 0; ptr = 0;
    endtask

    task automatic exec_run();
        bit reached = 0;
        repeat (2) @(negedge clk);
        chk(fetch_req && fetch_addr == 32'h0 && !mw_valid && !rd_err, "R1",
            "reset state", {fetch_addr[30:0], fetch_req}, 32'h1);
        rst_n = 1;
        for (int t = 0; t < 600 && !reached; t++) begin
            @(negedge clk);
            if (fetch_req && fetch_addr == 32'(ptr * 4)) reached = 1;
        end
        chk(reached, "R10", "end of program reached", fetch_addr, 32'(ptr * 4));
        for (int i = 0; i < NREG; i++)
            chk(regs[i] == exp_regs[i], "R3", $sformatf("reg %0d", i), regs[i], exp_regs[i]);
        chk(nw == exp_nw, "R5", "store count", 32'(nw), 32'(exp_nw));
        for (int i = 0; i < exp_nw && i < nw; i++) begin
            chk(wr_a[i] == exp_wa[i], "R5", "store address", wr_a[i], exp_wa[i]);
            chk(wr_d[i] == exp_wd[i], "R5", "store data", wr_d[i], exp_wd[i]);
        end
        chk(rd_err == exp_err, "R6", "error bit", 32'(rd_err), 32'(exp_err));
        chk(nbad == 0, "R6", "write to missing register", 32'(nbad), 32'h0);
        chk(nunsup == exp_unsup, "R8", "unsupported pulses", 32'(nunsup), 32'(exp_unsup));
        chk(irq == (exp_err && irq_en), "R7", "irq gating", 32'(irq), 32'(exp_err && irq_en));
        if (exp_err) begin
            err_clr = 1;
            @(negedge clk);
            err_clr = 0;
            chk(rd_err == 1'b0 && irq == 1'b0, "R7", "error cleared", 32'(rd_err), 32'h0);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc = 0; rst_n = 0; err_clr = 0; irq_en = 0; stall_mode = 0;
        // Sweep start index and count; stalls (R9) on alternate runs.
        for (int s = 0; s < 14; s++) begin
            for (int n = 1; n <= 4; n++) begin
                begin_run();
                stall_mode = (s + n) % 2;
                irq_en = n[0];
                add_load(s, n);
                add_store(s, 32'h0001_0000 + 32'(s * 64 + n * 4));
                put(32'h7000_0000 | 32'(s)); exp_unsup++;           // R8
                put({4'b1001, 12'h0, 8'd0, 1'b0, 7'd2});            // R4 zero-count load
                add_store(NREG - 1, 32'h0002_0000 + 32'(s));
                put({4'b1010, 12'h0, 8'd0, 1'b0, 7'd1});            // R4 zero-count store
                add_store(0, 32'h0003_0000 + 32'(n));
                exec_run();
            end
        end
        // Full-file load, then a run entirely past the end (R6).
        for (int m = 0; m < 2; m++) begin
            begin_run();
            stall_mode = m; irq_en = 1;
            add_load(0, NREG);
            add_store(NREG - 1, 32'h0004_0000);
            add_load(NREG + 20, 3);
            put(32'hF123_4567); exp_unsup++;
            add_store(5, 32'h0004_0010);
            exec_run();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule